// File: doc/BRIEF.md
# Daisy-Chained DAC Frame Sequencer

This block is the host side of a serial link that drives a string of octal DAC devices wired in series. All devices share one serial clock and one active-low chip-select/load line. The serial output of each device feeds the serial input of the next one. The host hands over one request carrying a command, a channel address and a data code for every device in the string. Any device can instead be marked idle, in which case it is sent a do-nothing word.

The sequencer builds one 32-bit word per device and concatenates the words so that the device farthest from the host receives its word first. It then drops the load line and clocks out every bit, most significant bit first. The serial clock is derived from the system clock by a fixed half-period count. When all bits are out, the sequencer raises the load line once, so that every device in the string acts on its word at the same instant. A one-cycle completion pulse marks that moment. Spacing rules between the load line and the serial clock edges are held by the same half-period count.

Top module: `dac_chain_seq`

## Requirements
- R1: Each device word is 32 bits, sent most significant bit first, laid out as eight zero pad bits, then a 4-bit command, then a 4-bit address, then a 16-bit data code, giving {8'h00, cmd, addr, data}.
- R2: Device index NUM_DEV-1 (farthest from the host) has its word sent first. Device index 0 has its word sent last.
- R3: A device whose idle flag is set receives the word {8'h00, 4'hF, 4'hF, 16'h0000}, whatever its command, address and data inputs hold.
- R4: One accepted request produces exactly one falling and one rising edge of the load line, with exactly NUM_DEV*32 serial clock rising edges between them.
- R5: The serial clock is low whenever the load line is high. Within a frame, each high phase and each low phase of the serial clock lasts HALF_CYC system clocks.
- R6: The serial data output changes only in the cycle the load line falls or in a cycle in which the serial clock falls. It is stable in every cycle in which the serial clock is high.
- R7: HALF_CYC system clocks pass from the load line falling to the first serial clock rise. HALF_CYC clocks pass from the last serial clock fall to the load line rising. Between frames the load line stays high for at least HALF_CYC clocks.
- R8: After reset the load line is high, the serial clock is low, and busy and done are low. A request is taken when req_valid and req_ready are both high. busy is high and req_ready is low from the clock after acceptance until HALF_CYC clocks after the load line rises.
- R9: done is high for exactly one cycle, the same cycle in which the load line rises.
- R10: A request presented while busy is high is not taken. It neither alters the frame in progress nor starts another frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_idle | input | NUM_DEV | Per-device idle flag (send the do-nothing word) |
| req_cmd | input | NUM_DEV*4 | Per-device command, device i at bits [4i+3:4i] |
| req_addr | input | NUM_DEV*4 | Per-device channel address, device i at bits [4i+3:4i] |
| req_data | input | NUM_DEV*16 | Per-device data code, device i at bits [16i+15:16i] |
| busy | output | 1 | Frame in progress or load line recovering |
| done | output | 1 | One-cycle pulse as the load line rises |
| ser_clk | output | 1 | Serial clock to the device string |
| ser_dout | output | 1 | Serial data to the first device |
| ser_load_n | output | 1 | Shared chip-select/load, active low |

## Verification
The assertions check on every cycle that the serial clock never runs while the load line is high and that the data line holds through each high phase of the clock. They also check that a load rise comes only after exactly the full bit count of rising edges, that the completion pulse coincides with the load rise, and that the load line stays high for the minimum time. What the assertions cannot see is what the words mean: the pad and field order, the reversed device order and the do-nothing substitution. The bench shows these by collecting the bits on each serial rise and decoding them into per-device words. It also shows the rejection of requests made during a frame, by comparing every cycle against a behavioural timeline model.

// File: rtl/dac_chain_pkg.sv
package dac_chain_pkg;
  localparam int WORD_W = 32;
  localparam int PAD_W  = 8;
  localparam int CMD_W  = 4;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 16;
  localparam logic [CMD_W-1:0]  IDLE_CMD  = 4'hF;
  localparam logic [ADDR_W-1:0] IDLE_ADDR = 4'hF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_TAIL,
    ST_RECOV
  } seq_state_t;
endpackage

// File: rtl/dac_rst_sync.sv
module dac_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/dac_frame_build.sv
module dac_frame_build
  import dac_chain_pkg::*;
#(
  parameter int NUM_DEV = 3
) (
  input  logic [NUM_DEV-1:0]        dev_idle,
  input  logic [NUM_DEV*CMD_W-1:0]  dev_cmd,
  input  logic [NUM_DEV*ADDR_W-1:0] dev_addr,
  input  logic [NUM_DEV*DATA_W-1:0] dev_data,
  output logic [NUM_DEV*WORD_W-1:0] frame
);
  // Device 0 sits in the low word; the top word is shifted out first,
  // so the farthest device's word leads the frame.
  for (genvar g = 0; g < NUM_DEV; g++) begin : g_word
    always_comb begin
      if (dev_idle[g]) begin
        frame[g*WORD_W +: WORD_W] = {{PAD_W{1'b0}}, IDLE_CMD, IDLE_ADDR, {DATA_W{1'b0}}};
      end else begin
        frame[g*WORD_W +: WORD_W] = {{PAD_W{1'b0}},
                                     dev_cmd[g*CMD_W +: CMD_W],
                                     dev_addr[g*ADDR_W +: ADDR_W],
                                     dev_data[g*DATA_W +: DATA_W]};
      end
    end
  end
endmodule

// File: rtl/dac_phase_timer.sv
module dac_phase_timer #(
  parameter int HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst_sn,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == LAST);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dac_bit_shifter.sv
module dac_bit_shifter #(
  parameter int TOTAL = 96
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             load,
  input  logic             shift,
  input  logic [TOTAL-1:0] frame,
  output logic             bit_out,
  output logic             last_bit
);
  localparam int BW = $clog2(TOTAL);

  logic [TOTAL-1:0] sh_q, sh_d;
  logic [BW-1:0]    left_q, left_d;

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    if (load) begin
      sh_d   = frame;
      left_d = BW'(TOTAL - 1);
    end else if (shift) begin
      sh_d   = {sh_q[TOTAL-2:0], 1'b0};
      left_d = left_q - BW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (load || shift) begin
      sh_q   <= sh_d;
      left_q <= left_d;
    end
  end

  assign bit_out  = sh_q[TOTAL-1];
  assign last_bit = (left_q == '0);
endmodule

// File: rtl/dac_chain_seq.sv
module dac_chain_seq
  import dac_chain_pkg::*;
#(
  parameter int NUM_DEV  = 3,
  parameter int HALF_CYC = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [NUM_DEV-1:0]        req_idle,
  input  logic [NUM_DEV*CMD_W-1:0]  req_cmd,
  input  logic [NUM_DEV*ADDR_W-1:0] req_addr,
  input  logic [NUM_DEV*DATA_W-1:0] req_data,
  output logic                      busy,
  output logic                      done,
  output logic                      ser_clk,
  output logic                      ser_dout,
  output logic                      ser_load_n
);
  localparam int TOTAL = NUM_DEV * WORD_W;
  localparam int RW    = $clog2(TOTAL + 1);
  localparam int HW    = $clog2(HALF_CYC + 2);

  logic       rst_sn;
  seq_state_t state_q, state_d;
  logic       tick, load, shift, last_bit;
  logic       sck_q, load_n_q, done_q;
  logic [TOTAL-1:0] frame;

  dac_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  dac_frame_build #(.NUM_DEV(NUM_DEV)) u_build (
    .dev_idle(req_idle), .dev_cmd(req_cmd), .dev_addr(req_addr),
    .dev_data(req_data), .frame(frame)
  );

  dac_phase_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk(clk), .rst_sn(rst_sn), .run(state_q != ST_IDLE), .tick(tick)
  );

  dac_bit_shifter #(.TOTAL(TOTAL)) u_shift (
    .clk(clk), .rst_sn(rst_sn), .load(load), .shift(shift), .frame(frame),
    .bit_out(ser_dout), .last_bit(last_bit)
  );

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    shift   = 1'b0;
    case (state_q)
      ST_IDLE:  if (req_valid) begin state_d = ST_LEAD; load = 1'b1; end
      ST_LEAD:  if (tick) state_d = ST_HIGH;
      ST_HIGH:  if (tick) begin
                  if (last_bit) state_d = ST_TAIL;
                  else begin state_d = ST_LOW; shift = 1'b1; end
                end
      ST_LOW:   if (tick) state_d = ST_HIGH;
      ST_TAIL:  if (tick) state_d = ST_RECOV;
      ST_RECOV: if (tick) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q  <= ST_IDLE;
      sck_q    <= 1'b0;
      load_n_q <= 1'b1;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      sck_q    <= (state_d == ST_HIGH);
      load_n_q <= (state_d == ST_IDLE) || (state_d == ST_RECOV);
      done_q   <= (state_q == ST_TAIL) && tick;
    end
  end

  assign ser_clk    = sck_q;
  assign ser_load_n = load_n_q;
  assign done       = done_q;
  assign busy       = (state_q != ST_IDLE);
  assign req_ready  = (state_q == ST_IDLE);

  // Observation counters for the edge-count and load-high-time checks.
  logic          sck_prev_q;
  logic [RW-1:0] rise_cnt_q;
  logic [HW-1:0] hi_cnt_q;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      sck_prev_q <= 1'b0;
      rise_cnt_q <= '0;
      hi_cnt_q   <= HW'(HALF_CYC);
    end else begin
      sck_prev_q <= ser_clk;
      if (ser_load_n)                  rise_cnt_q <= '0;
      else if (ser_clk && !sck_prev_q) rise_cnt_q <= rise_cnt_q + RW'(1);
      if (!ser_load_n)                 hi_cnt_q <= '0;
      else if (hi_cnt_q < HW'(HALF_CYC)) hi_cnt_q <= hi_cnt_q + HW'(1);
    end
  end

  p_edge_count_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(ser_load_n) |-> (rise_cnt_q == RW'(TOTAL)));

  p_clk_quiet_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    ser_clk |-> !ser_load_n);

  p_dout_steady_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    ser_clk |-> $stable(ser_dout));

  p_load_high_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(ser_load_n) |-> (hi_cnt_q >= HW'(HALF_CYC)));

  p_done_at_load_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    done |-> $rose(ser_load_n));
endmodule

// File: tb/dac_chain_seq_tb.sv
module dac_chain_seq_tb;
  localparam int N   = 3;
  localparam int H   = 2;
  localparam int TOT = N * 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst_n, req_valid, req_ready, busy, done;
  logic            ser_clk, ser_dout, ser_load_n;
  logic [N-1:0]    req_idle;
  logic [N*4-1:0]  req_cmd, req_addr;
  logic [N*16-1:0] req_data;

  dac_chain_seq #(.NUM_DEV(N), .HALF_CYC(H)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_idle(req_idle), .req_cmd(req_cmd), .req_addr(req_addr), .req_data(req_data),
    .busy(busy), .done(done), .ser_clk(ser_clk), .ser_dout(ser_dout),
    .ser_load_n(ser_load_n)
  );

  typedef struct packed { logic csn; logic sck; logic sdi; logic bsy; logic dn; } exp_t;
  localparam exp_t IDLE_E = '{csn: 1'b1, sck: 1'b0, sdi: 1'b0, bsy: 1'b0, dn: 1'b0};

  int n_checks = 0, n_fail = 0, frames_exp = 0, frames_got = 0;
  exp_t        q[$];
  exp_t        cur = IDLE_E;
  logic [31:0] fexp[$];
  logic        got[$];

  function automatic logic [31:0] word_of(int d);
    if (req_idle[d]) return {8'h00, 4'hF, 4'hF, 16'h0000};
    return {8'h00, req_cmd[d*4 +: 4], req_addr[d*4 +: 4], req_data[d*16 +: 16]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // Behavioural timeline model: one expected output tuple per clock.
  task automatic push_frame();
    logic b[$];
    for (int d = N - 1; d >= 0; d--) begin
      logic [31:0] w;
      w = word_of(d);
      fexp.push_back(w);
      for (int k = 31; k >= 0; k--) b.push_back(w[k]);
    end
    frames_exp++;
    for (int h = 0; h < H; h++) q.push_back('{1'b0, 1'b0, b[0], 1'b1, 1'b0});
    for (int i = 0; i < TOT; i++) begin
      for (int h = 0; h < H; h++) q.push_back('{1'b0, 1'b1, b[i], 1'b1, 1'b0});
      if (i < TOT - 1)
        for (int h = 0; h < H; h++) q.push_back('{1'b0, 1'b0, b[i+1], 1'b1, 1'b0});
    end
    for (int h = 0; h < H; h++) q.push_back('{1'b0, 1'b0, b[TOT-1], 1'b1, 1'b0});
    for (int h = 0; h < H; h++) q.push_back('{1'b1, 1'b0, 1'b0, 1'b1, (h == 0)});
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      cur = IDLE_E;
    end else begin
      if (req_valid && !cur.bsy) push_frame();
      if (q.size() > 0) cur = q.pop_front();
      else              cur = IDLE_E;
    end
  end

  logic prev_sck = 1'b0, prev_csn = 1'b1;
  int   zero_run = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      check(ser_load_n == cur.csn, "R4 load line", 32'(ser_load_n), 32'(cur.csn));
      check(ser_clk == cur.sck, "R5 serial clock", 32'(ser_clk), 32'(cur.sck));
      if (!cur.csn) check(ser_dout == cur.sdi, "R6 serial data", 32'(ser_dout), 32'(cur.sdi));
      check(busy == cur.bsy, "R8 busy", 32'(busy), 32'(cur.bsy));
      check(req_ready == !cur.bsy, "R8 ready", 32'(req_ready), 32'(!cur.bsy));
      check(done == cur.dn, "R9 done", 32'(done), 32'(cur.dn));

      if (ser_clk && !prev_sck) begin
        if (got.size() == 0) check(zero_run == H, "R7 lead gap", 32'(zero_run), 32'(H));
        got.push_back(ser_dout);
      end
      if (ser_clk || ser_load_n) zero_run = 0;
      else                       zero_run++;
      if (ser_load_n && !prev_csn) begin
        frames_got++;
        check(got.size() == TOT, "R4 rise count", 32'(got.size()), 32'(TOT));
        for (int k = 0; k < N; k++) begin
          logic [31:0] w, e;
          w = '0;
          for (int j = 0; j < 32; j++)
            w = {w[30:0], (k*32 + j < got.size()) ? got[k*32 + j] : 1'b0};
          e = (fexp.size() > 0) ? fexp.pop_front() : 32'hDEAD_BEEF;
          check(w == e, "R1/R2/R3 device word", w, e);
        end
        got.delete();
      end
      if (!ser_load_n && prev_csn) zero_run = 1;
      prev_sck = ser_clk;
      prev_csn = ser_load_n;
    end
  end

  // Trail gap: cycles with clock low before the load line rises.
  int trail_seen = 0;
  always @(negedge clk) begin
    if (rst_n && !ser_load_n && !ser_clk && got.size() == TOT) trail_seen++;
    if (rst_n && ser_load_n && trail_seen != 0) begin
      check(trail_seen == H, "R7 trail gap", 32'(trail_seen), 32'(H));
      trail_seen = 0;
    end
  end

  task automatic send(input logic [N-1:0] idl, input logic [N*4-1:0] c,
                      input logic [N*4-1:0] a, input logic [N*16-1:0] d);
    do @(negedge clk); while (!req_ready);
    req_idle = idl; req_cmd = c; req_addr = a; req_data = d;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    check(frames_got == frames_exp, "R10 frame count", 32'(frames_got), 32'(frames_exp));
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL R8 watchdog expired at %0t: actual busy %b expected idle", $time, busy);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0;
    req_idle = '0; req_cmd = '0; req_addr = '0; req_data = '0;
    repeat (3) @(negedge clk);
    check(ser_load_n == 1'b1 && ser_clk == 1'b0 && busy == 1'b0 && done == 1'b0,
          "R8 reset state", {28'h0, ser_load_n, ser_clk, busy, done}, 32'h8);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1/R2: all devices active, distinct fields
    send(3'b000, {4'h3, 4'h0, 4'h2}, {4'h7, 4'h1, 4'h0},
         {16'hA55A, 16'h0001, 16'hFFFF});
    wait_idle();
    // R3: middle device idle with non-trivial inputs
    send(3'b010, {4'h1, 4'h2, 4'h4}, {4'hF, 4'h5, 4'h2},
         {16'h1234, 16'hBEEF, 16'h8000});
    wait_idle();
    // R3: every device idle
    send(3'b111, {4'h0, 4'h1, 4'h3}, {4'h6, 4'h6, 4'h6},
         {16'hFFFF, 16'hFFFF, 16'hFFFF});
    wait_idle();
    // R10: a request during a frame is dropped
    send(3'b100, {4'h3, 4'h3, 4'h3}, {4'h0, 4'h3, 4'h5},
         {16'h0F0F, 16'hF0F0, 16'h7FFF});
    repeat (40) @(negedge clk);
    req_idle = 3'b000; req_cmd = {3{4'h4}}; req_addr = {3{4'hF}}; req_data = '1;
    req_valid = 1'b1;
    repeat (20) @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    // R7/R8: back-to-back requests
    send(3'b001, {4'h0, 4'h2, 4'h9}, {4'h1, 4'h2, 4'h3}, {16'h0000, 16'h5555, 16'h3333});
    send(3'b000, {4'h1, 4'h1, 4'h1}, {4'hE, 4'hD, 4'hC}, {16'hCAFE, 16'h0002, 16'h4000});
    wait_idle();
    finish_run();
  end
endmodule